// File: doc/BRIEF.md
# Write-Locked Clock Gate Controller

This block owns the enable decision for a set of clock gates and exposes their control fields through a small 32-bit register port. Every gate can be run by software, which opens or closes it through a register bit. It can also be run by hardware, which opens or closes it through a dedicated request pin. A read-only status bit lets software poll until a change has actually taken effect. The block only produces the per-gate enable; it does not generate or switch any clock.

Control writes are guarded. The access word at word address 0 has to be written with an exact unlock value before any gate register takes a write. An exact lock value closes access again. Any other value written to word 0 leaves the access state as it was. A gate can be built so that it can never be switched off while software controls it. A gate can also hold its enable for a selectable number of cycles after its demand goes away, which covers short idle gaps.

Top module: `ckg_ctrl`

## Requirements
- R1: While rst_ni is low, gate_en_o is all zero, access is locked, and every gate register reads 0. A gate register at 0 means hardware control with hysteresis off.
- R2: Writing 0x00A5A501 to word 0 unlocks access. Writing 0x00A5A500 locks it. Reading word 0 returns the access state in bit 0, with all other bits 0.
- R3: Any other value written to word 0 leaves the access state unchanged. This includes values with a wrong upper key or with any of bits 7:1 set.
- R4: While access is locked, writes to gate registers are ignored.
- R5: Gate g sits at word address g+1. Its fields are: bit 0 software enable, bit 1 control select (1 = software, 0 = hardware), bit 2 status (read-only), bit 3 hysteresis enable, bit 4 long hysteresis. All other bits read 0. Unmapped words read 0 and ignore writes.
- R6: Under software control, gate_en_o[g] follows the software enable bit one clock after the write edge.
- R7: Under hardware control, the software enable bit has no effect. gate_en_o[g] follows hw_req_i[g] three clock edges after the input changes: two synchroniser stages plus the gate register.
- R8: The status bit equals gate_en_o[g] delayed by SYNC_STAGES clocks (default 2).
- R9: A gate marked in NO_DISABLE_MASK stays enabled under software control even while its enable bit is 0.
- R10: With hysteresis on, the gate turns off HYST_SHORT (8) cycles after demand drops, or HYST_LONG (64) cycles if bit 4 is set. Turning on is never delayed.
- R11: If demand returns during a turn-off countdown, the gate stays on. The next turn-off then counts the full delay again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_req_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | Write when 1, read when 0 |
| bus_addr_i | input | ADDR_W | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| hw_req_i | input | N_GATES | Hardware gate requests, asynchronous |
| gate_en_o | output | N_GATES | Per-gate clock enable |

## Verification
The bench looks for the access-word corner cases: near-miss keys, and keys with stray low bits. A controller that checks only the upper bits would unlock on these, and the locked gate write that follows would then stick. The bench counts the exact edge at which a gate drops after both the short and the long hysteresis. An off-by-one counter, or a delay applied to turn-on, shows up as a wrong enable level on one specific cycle. It also cancels a countdown partway through and then times a fresh one, which catches a counter that is not cleared when demand returns. Finally it checks that the enable bit has no effect in hardware mode, that a never-disable gate stays on, and that the status bit lags by exactly two cycles.

// File: rtl/ckg_pkg.sv
package ckg_pkg;
  localparam int unsigned BUS_W = 32;
  localparam logic [31:0] KEY_OPEN  = 32'h00A5_A501;
  localparam logic [31:0] KEY_CLOSE = 32'h00A5_A500;
  localparam int unsigned F_EN    = 0;
  localparam int unsigned F_SEL   = 1;
  localparam int unsigned F_STAT  = 2;
  localparam int unsigned F_HEN   = 3;
  localparam int unsigned F_HLONG = 4;

  typedef struct packed {
    logic hlong;
    logic hen;
    logic sel;
    logic en;
  } gate_cfg_t;
endpackage

// File: rtl/ckg_sync.sv
module ckg_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned W      = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/ckg_access_lock.sv
module ckg_access_lock
  import ckg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic             open_o
);
  // only the two exact words act; everything else is dropped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             open_o <= 1'b0;
    else if (wr_i && wdata_i == KEY_OPEN)    open_o <= 1'b1;
    else if (wr_i && wdata_i == KEY_CLOSE)   open_o <= 1'b0;
  end
endmodule

// File: rtl/ckg_gate_slice.sv
module ckg_gate_slice
  import ckg_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned HYST_SHORT  = 8,
  parameter int unsigned HYST_LONG   = 64,
  parameter bit          NO_DISABLE  = 1'b0
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      cfg_we_i,
  input  gate_cfg_t cfg_d_i,
  input  logic      hw_req_i,
  output gate_cfg_t cfg_o,
  output logic      gate_o,
  output logic      status_o
);
  localparam int unsigned CNT_W = $clog2(HYST_LONG + 1);

  gate_cfg_t        cfg_q;
  logic             hw_sync;
  logic             demand;
  logic             gate_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= '0;
    else if (cfg_we_i) cfg_q <= cfg_d_i;
  end

  ckg_sync #(.STAGES(SYNC_STAGES), .W(1)) u_req_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(hw_req_i), .q_o(hw_sync)
  );

  always_comb begin
    demand = cfg_q.sel ? (cfg_q.en | NO_DISABLE) : hw_sync;
    limit  = cfg_q.hlong ? CNT_W'(HYST_LONG - 1) : CNT_W'(HYST_SHORT - 1);
  end

  // turn-on is immediate; turn-off waits out the countdown when enabled
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q <= 1'b0;
      cnt_q  <= '0;
    end else if (demand) begin
      gate_q <= 1'b1;
      cnt_q  <= '0;
    end else if (gate_q) begin
      if (!cfg_q.hen || cnt_q >= limit) begin
        gate_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  ckg_sync #(.STAGES(SYNC_STAGES), .W(1)) u_stat_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(gate_q), .q_o(status_o)
  );

  assign cfg_o  = cfg_q;
  assign gate_o = gate_q;
endmodule

// File: rtl/ckg_ctrl.sv
module ckg_ctrl
  import ckg_pkg::*;
#(
  parameter int unsigned         N_GATES         = 4,
  parameter int unsigned         ADDR_W          = 4,
  parameter int unsigned         SYNC_STAGES     = 2,
  parameter int unsigned         HYST_SHORT      = 8,
  parameter int unsigned         HYST_LONG       = 64,
  parameter logic [N_GATES-1:0]  NO_DISABLE_MASK = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_req_i,
  input  logic               bus_we_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [BUS_W-1:0]   bus_wdata_i,
  output logic [BUS_W-1:0]   bus_rdata_o,
  input  logic [N_GATES-1:0] hw_req_i,
  output logic [N_GATES-1:0] gate_en_o
);
  logic               bus_wr;
  logic               unlocked;
  gate_cfg_t          wr_cfg;
  gate_cfg_t          cfg_w [N_GATES];
  logic [N_GATES-1:0] sel_v, en_v, hen_v, hlong_v, status_v;
  logic               unused_wdata;

  assign bus_wr       = bus_req_i & bus_we_i;
  assign wr_cfg       = '{hlong: bus_wdata_i[F_HLONG], hen: bus_wdata_i[F_HEN],
                          sel: bus_wdata_i[F_SEL], en: bus_wdata_i[F_EN]};
  assign unused_wdata = ^{bus_wdata_i[BUS_W-1:F_HLONG+1], bus_wdata_i[F_STAT]};

  ckg_access_lock u_lock (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_i(bus_wr && bus_addr_i == '0),
    .wdata_i(bus_wdata_i), .open_o(unlocked)
  );

  for (genvar g = 0; g < N_GATES; g++) begin : g_gate
    ckg_gate_slice #(
      .SYNC_STAGES(SYNC_STAGES), .HYST_SHORT(HYST_SHORT),
      .HYST_LONG(HYST_LONG), .NO_DISABLE(NO_DISABLE_MASK[g])
    ) u_slice (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .cfg_we_i(bus_wr && unlocked && bus_addr_i == ADDR_W'(g + 1)),
      .cfg_d_i(wr_cfg), .hw_req_i(hw_req_i[g]),
      .cfg_o(cfg_w[g]), .gate_o(gate_en_o[g]), .status_o(status_v[g])
    );
    assign sel_v[g]   = cfg_w[g].sel;
    assign en_v[g]    = cfg_w[g].en;
    assign hen_v[g]   = cfg_w[g].hen;
    assign hlong_v[g] = cfg_w[g].hlong;
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == '0) bus_rdata_o[0] = unlocked;
    for (int g = 0; g < N_GATES; g++) begin
      if (bus_addr_i == ADDR_W'(g + 1)) begin
        bus_rdata_o[F_EN]    = en_v[g];
        bus_rdata_o[F_SEL]   = sel_v[g];
        bus_rdata_o[F_STAT]  = status_v[g];
        bus_rdata_o[F_HEN]   = hen_v[g];
        bus_rdata_o[F_HLONG] = hlong_v[g];
      end
    end
  end
endmodule

// File: rtl/ckg_ctrl_chk.sv
module ckg_ctrl_chk
  import ckg_pkg::*;
#(
  parameter int unsigned        N_GATES         = 4,
  parameter int unsigned        ADDR_W          = 4,
  parameter int unsigned        SYNC_STAGES     = 2,
  parameter logic [N_GATES-1:0] NO_DISABLE_MASK = '0
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               bus_req_i,
  input logic               bus_we_i,
  input logic [ADDR_W-1:0]  bus_addr_i,
  input logic [BUS_W-1:0]   bus_wdata_i,
  input logic               unlocked_i,
  input logic [N_GATES-1:0] sel_i,
  input logic [N_GATES-1:0] en_i,
  input logic [N_GATES-1:0] status_i,
  input logic [N_GATES-1:0] gate_i
);
  logic acc_wr;
  assign acc_wr = bus_req_i && bus_we_i && bus_addr_i == '0;

  logic [SYNC_STAGES-1:0][N_GATES-1:0] lag_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lag_q <= '0;
    end else begin
      lag_q[0] <= gate_i;
      for (int s = 1; s < SYNC_STAGES; s++) lag_q[s] <= lag_q[s-1];
    end
  end

  p_unlock_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_wr && bus_wdata_i == KEY_OPEN) |=> unlocked_i);

  p_lock_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_wr && bus_wdata_i == KEY_CLOSE) |=> !unlocked_i);

  p_bad_key_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_wr && bus_wdata_i != KEY_OPEN && bus_wdata_i != KEY_CLOSE) |=> $stable(unlocked_i));

  for (genvar g = 0; g < N_GATES; g++) begin : g_chk
    p_locked_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!unlocked_i && bus_req_i && bus_we_i && bus_addr_i == ADDR_W'(g + 1))
      |=> ($stable(sel_i[g]) && $stable(en_i[g])));

    p_sw_on_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_i[g] && en_i[g] && !gate_i[g]) |=> gate_i[g]);

    p_status_lag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      status_i[g] == lag_q[SYNC_STAGES-1][g]);

    if (NO_DISABLE_MASK[g]) begin : g_nd
      p_never_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sel_i[g] |=> gate_i[g]);
    end
  end
endmodule

bind ckg_ctrl ckg_ctrl_chk #(
  .N_GATES(N_GATES), .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES),
  .NO_DISABLE_MASK(NO_DISABLE_MASK)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_req_i(bus_req_i), .bus_we_i(bus_we_i),
  .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .unlocked_i(unlocked),
  .sel_i(sel_v), .en_i(en_v), .status_i(status_v), .gate_i(gate_en_o)
);

// File: tb/ckg_ctrl_test.sv
module ckg_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int AW = 4;
  localparam logic [N-1:0] NDM = 4'b1000;
  localparam logic [31:0] RMASK = 32'hFFFF_FFFB;

  typedef struct packed {
    logic [AW-1:0] addr;
    logic [31:0]   wdata;
    logic [31:0]   exp_v;
    logic [7:0]    req;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{4'd0, 32'h00A5A501, 32'h00000001, 8'd2},  // R2 unlock
    '{4'd1, 32'hFFFFFFFF, 32'h0000001B, 8'd5},  // R5 writable fields only
    '{4'd2, 32'hFFFFFFE4, 32'h00000000, 8'd5},  // R5 status and spare bits
    '{4'd0, 32'h00A5A401, 32'h00000001, 8'd3},  // R3 wrong key
    '{4'd0, 32'h00A5A503, 32'h00000001, 8'd3},  // R3 stray low bits
    '{4'd0, 32'h00A5A500, 32'h00000000, 8'd2},  // R2 lock
    '{4'd1, 32'h00000000, 32'h0000001B, 8'd4},  // R4 locked write dropped
    '{4'd0, 32'h12A5A501, 32'h00000000, 8'd3},  // R3 wrong upper byte
    '{4'd0, 32'h00A5A501, 32'h00000001, 8'd2},  // R2 unlock again
    '{4'd1, 32'h00000000, 32'h00000000, 8'd5},  // R5 clear
    '{4'd5, 32'hFFFFFFFF, 32'h00000000, 8'd5}   // R5 unmapped word
  };

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          bus_req = 1'b0, bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [N-1:0]  hw_req = '0;
  logic [N-1:0]  gate_en;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ckg_ctrl #(.N_GATES(N), .ADDR_W(AW), .NO_DISABLE_MASK(NDM)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .bus_req_i(bus_req), .bus_we_i(bus_we),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .hw_req_i(hw_req), .gate_en_o(gate_en)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp_v);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] d;
    repeat (3) step();
    chk("R1 gate_en", 32'(gate_en), 32'd0);
    for (int a = 0; a <= N; a++) begin
      rd(AW'(a), d);
      chk("R1 reg", d, 32'd0);
    end
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      wr(VECS[i].addr, VECS[i].wdata);
      rd(VECS[i].addr, d);
      chk($sformatf("R%0d vec %0d", VECS[i].req, i), d & RMASK, VECS[i].exp_v);
    end

    // R6 / R8: software on, then status lag
    wr(4'd1, 32'h3);
    chk("R6 not before edge", 32'(gate_en[0]), 32'd0);
    step();
    chk("R6 on", 32'(gate_en[0]), 32'd1);
    rd(4'd1, d); chk("R8 lag1", 32'(d[2]), 32'd0);
    step(); rd(4'd1, d); chk("R8 lag2", 32'(d[2]), 32'd0);
    step(); rd(4'd1, d); chk("R8 settled", 32'(d[2]), 32'd1);

    // R10 short hysteresis
    wr(4'd1, 32'h0A);
    repeat (7) step();
    chk("R10 short hold", 32'(gate_en[0]), 32'd1);
    step();
    chk("R10 short off", 32'(gate_en[0]), 32'd0);

    // R10 turn-on undelayed
    wr(4'd1, 32'h1B);
    step();
    chk("R10 on fast", 32'(gate_en[0]), 32'd1);

    // R10 long hysteresis
    wr(4'd1, 32'h1A);
    repeat (63) step();
    chk("R10 long hold", 32'(gate_en[0]), 32'd1);
    step();
    chk("R10 long off", 32'(gate_en[0]), 32'd0);

    // R11 cancel countdown, then fresh count
    wr(4'd1, 32'h0B);
    step();
    wr(4'd1, 32'h0A);
    repeat (3) step();
    wr(4'd1, 32'h0B);
    repeat (10) step();
    chk("R11 cancelled", 32'(gate_en[0]), 32'd1);
    wr(4'd1, 32'h0A);
    repeat (7) step();
    chk("R11 fresh count", 32'(gate_en[0]), 32'd1);
    step();
    chk("R11 off", 32'(gate_en[0]), 32'd0);

    // R7 hardware mode: enable bit ignored, three-edge latency
    wr(4'd2, 32'h01);
    repeat (2) step();
    chk("R7 en ignored", 32'(gate_en[1]), 32'd0);
    hw_req[1] = 1'b1;
    step(); step();
    chk("R7 rise early", 32'(gate_en[1]), 32'd0);
    step();
    chk("R7 rise", 32'(gate_en[1]), 32'd1);
    hw_req[1] = 1'b0;
    step(); step();
    chk("R7 fall early", 32'(gate_en[1]), 32'd1);
    step();
    chk("R7 fall", 32'(gate_en[1]), 32'd0);

    // R9 never-disable gate
    wr(4'd4, 32'h02);
    wr(4'd3, 32'h02);
    step();
    chk("R9 held on", 32'(gate_en[3]), 32'd1);
    chk("R9 normal off", 32'(gate_en[2]), 32'd0);

    // R4 locked write has no effect on gate
    wr(4'd0, 32'h00A5A500);
    wr(4'd3, 32'h03);
    step(); step();
    chk("R4 gate", 32'(gate_en[2]), 32'd0);
    rd(4'd3, d); chk("R4 reg", d & RMASK, 32'h02);

    // R1 reset in mid-run
    rst_ni = 1'b0;
    #1 chk("R1 async gate", 32'(gate_en), 32'd0);
    rd(4'd0, d); chk("R1 lock", d, 32'd0);
    rd(4'd4, d); chk("R1 reg clear", d, 32'd0);
    step();
    rst_ni = 1'b1;
    step();

    summary();
  end
endmodule